// File: doc/BRIEF.md
# Two-Master Locked Read-Modify-Write Bus Arbiter

This block shares one memory bus between two masters and lets either of them perform an atomic read-modify-write. A master opens an atomic sequence with a locked read. From then on only that master can be granted, and it must finish with a locked write to the same address. Any other outcome ends the lock at once, so a faulting or misbehaving sequence can never hold the bus until reset. Such outcomes are an exception raised by the owner, a malformed follow-up request, or a write that never arrives within a bounded window.

Each master presents a request with its own lock, write-select, illegal-operand flag, address and write data. Each master also has an abort line with a cause bit that separates exceptions from interrupts. The arbiter samples requests on a clock edge and answers in the next cycle with a grant. The grant comes with either a done strobe, which drives a bus transaction, or an error strobe, which drives none. A free cycle follows every response. The lock state and a sticky watchdog timeout flag are outputs.

Top module: `lock_arbiter`

## Requirements
- R1: After reset no grant, done or error is asserted, the bus is idle, `locked_o` is 0 and `timeout_o` is 0.
- R2: An accepted request is answered in the cycle after the edge that sampled it. The answer is a one-cycle grant with a one-cycle done strobe, and read data is valid on `rdata_o` in that same cycle. No request is accepted on the edge that ends a response cycle.
- R3: When both masters request while the bus is unlocked, the master that was not granted last wins. After reset master 0 is favoured.
- R4: A legal request with lock=1 and we=0 takes the lock. `locked_o` is high from its response cycle onward, and while it stays high the other master is never granted, even while it requests.
- R5: While locked, a legal lock=1, we=1 request from the owner to the locked address performs the write with done, and `locked_o` is low in the cycle after that response.
- R6: While locked, any other owner request (another address, lock=0, or a read) gets an error with no bus transaction and releases the lock after its response.
- R7: A request with the illegal-operand flag set gets an error and no bus transaction. It never takes the lock, and from the owner it releases the lock.
- R8: An abort with cause 0 (exception) from the owner releases the lock at the next edge, with no grant in that cycle. An abort with cause 1 (interrupt), or any abort from the non-owner, leaves the lock unchanged.
- R9: The lock is held for at most WD_LIMIT cycles. When that window runs out the lock is released and `timeout_o` rises. `timeout_o` is then cleared only by reset.
- R10: A lock=1, we=1 request while no lock is held gets an error and no bus transaction.
- R11: `bus_en_o` is high only in a done cycle. In that cycle `bus_addr_o`, `bus_we_o` and `bus_wdata_o` carry the granted request's address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 2 | Request, bit m for master m |
| lock_i | input | 2 | Locked-access flag per master |
| we_i | input | 2 | 1 = write, 0 = read, per master |
| bad_op_i | input | 2 | Illegal-operand flag per master |
| abort_i | input | 2 | Abort strobe per master |
| abort_irq_i | input | 2 | Abort cause per master: 1 = interrupt, 0 = exception |
| addr_i | input | 2*AW | Address, master m at bits [m*AW +: AW] |
| wdata_i | input | 2*DW | Write data, master m at bits [m*DW +: DW] |
| gnt_o | output | 2 | One-hot grant in the response cycle |
| done_o | output | 2 | Completed transaction strobe |
| err_o | output | 2 | Error response strobe |
| rdata_o | output | DW | Read data, valid with done of a read |
| locked_o | output | 1 | Bus is locked |
| timeout_o | output | 1 | Sticky watchdog timeout flag |
| bus_en_o | output | 1 | Bus transaction active |
| bus_we_o | output | 1 | Bus write |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |

## Verification
The hardest condition to reach from the ports is a lock held while the other master is already waiting. The owner's closing write then has to win against that pending request on the exact edge it arrives. The bench gets there by opening a lock, raising the second master's request and holding it for several cycles. Only then does it send the owner's write. It checks that the write is served first and that the waiting read then returns the freshly written value. Abort causes and the watchdog window are reached the same way: the bench opens a lock and then either injects the abort lines one cycle at a time or stays silent and counts the locked cycles.

// File: rtl/lock_arbiter.sv
module lock_arbiter #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int WD_LIMIT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      req_i,
  input  logic [1:0]      lock_i,
  input  logic [1:0]      we_i,
  input  logic [1:0]      bad_op_i,
  input  logic [1:0]      abort_i,
  input  logic [1:0]      abort_irq_i,
  input  logic [2*AW-1:0] addr_i,
  input  logic [2*DW-1:0] wdata_i,
  output logic [1:0]      gnt_o,
  output logic [1:0]      done_o,
  output logic [1:0]      err_o,
  output logic [DW-1:0]   rdata_o,
  output logic            locked_o,
  output logic            timeout_o,
  output logic            bus_en_o,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i
);
  localparam int WDW = (WD_LIMIT > 2) ? $clog2(WD_LIMIT) : 1;

  logic [1:0]    gnt_q;
  logic          bus_q, we_q, fin_q, locked_q, owner_q, rr_q, to_q;
  logic [AW-1:0] addr_q, lk_addr_q;
  logic [DW-1:0] wdata_q;
  logic [WDW-1:0] wd_q;

  logic          busy, sel, s_lock, s_we, s_bad;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic [1:0]    elig;
  logic          exc_kill, rel_norm, wd_exp, accept, lk_wr_ok, go_bus, take;

  assign busy    = |gnt_q;
  assign elig    = locked_q ? (req_i & (owner_q ? 2'b10 : 2'b01)) : req_i;
  assign sel     = (elig == 2'b11) ? rr_q : elig[1];
  assign s_lock  = lock_i[sel];
  assign s_we    = we_i[sel];
  assign s_bad   = bad_op_i[sel];
  assign s_addr  = sel ? addr_i[2*AW-1:AW] : addr_i[AW-1:0];
  assign s_wdata = sel ? wdata_i[2*DW-1:DW] : wdata_i[DW-1:0];

  assign exc_kill = locked_q & abort_i[owner_q] & ~abort_irq_i[owner_q];
  assign rel_norm = locked_q & busy & fin_q;
  assign wd_exp   = locked_q & (wd_q == WDW'(WD_LIMIT - 1)) & ~rel_norm & ~exc_kill;
  assign accept   = ~busy & (|elig) & ~exc_kill & ~wd_exp;

  assign lk_wr_ok = s_lock & s_we & ~s_bad & (s_addr == lk_addr_q);
  assign go_bus   = locked_q ? lk_wr_ok : (~s_bad & ~(s_lock & s_we));
  assign take     = ~locked_q & ~s_bad & s_lock & ~s_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q     <= '0;
      bus_q     <= 1'b0;
      we_q      <= 1'b0;
      fin_q     <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rr_q      <= 1'b0;
      locked_q  <= 1'b0;
      owner_q   <= 1'b0;
      lk_addr_q <= '0;
      wd_q      <= '0;
      to_q      <= 1'b0;
    end else begin
      gnt_q <= accept ? (sel ? 2'b10 : 2'b01) : 2'b00;
      if (accept) begin
        bus_q   <= go_bus;
        we_q    <= s_we;
        addr_q  <= s_addr;
        wdata_q <= s_wdata;
        fin_q   <= locked_q;
        rr_q    <= ~sel;
      end
      if (accept && take) begin
        locked_q  <= 1'b1;
        owner_q   <= sel;
        lk_addr_q <= s_addr;
        wd_q      <= '0;
      end else if (rel_norm || exc_kill || wd_exp) begin
        locked_q <= 1'b0;
      end else if (locked_q) begin
        wd_q <= wd_q + WDW'(1);
      end
      if (wd_exp) to_q <= 1'b1;
    end
  end

  assign gnt_o       = gnt_q;
  assign done_o      = gnt_q & {2{bus_q}};
  assign err_o       = gnt_q & {2{~bus_q}};
  assign bus_en_o    = busy & bus_q;
  assign bus_we_o    = bus_en_o & we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign rdata_o     = (bus_en_o && !we_q) ? bus_rdata_i : '0;
  assign locked_o    = locked_q;
  assign timeout_o   = to_q;
endmodule

// File: rtl/lock_arbiter_chk.sv
module lock_arbiter_chk #(
  parameter int WD_LIMIT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] gnt_o,
  input logic [1:0] done_o,
  input logic [1:0] err_o,
  input logic       locked_o,
  input logic       timeout_o,
  input logic       bus_en_o
);
  logic lk_d, own_c;
  int   lk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_d   <= 1'b0;
      own_c  <= 1'b0;
      lk_cnt <= 0;
    end else begin
      lk_d <= locked_o;
      if (locked_o && !lk_d) own_c <= gnt_o[1];
      lk_cnt <= locked_o ? lk_cnt + 1 : 0;
    end
  end

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  a_r2_free_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != 2'b00) |=> (gnt_o == 2'b00));
  a_r2_resp_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_o & err_o) == 2'b00) && ((done_o | err_o) == gnt_o));
  a_r4_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && lk_d) |-> !(own_c ? gnt_o[0] : gnt_o[1]));
  a_r9_bounded_lock: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (lk_cnt < WD_LIMIT));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> timeout_o);
  a_r9_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (!locked_o && $past(locked_o)));
  a_r11_bus_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en_o == (done_o != 2'b00));
endmodule

bind lock_arbiter lock_arbiter_chk #(.WD_LIMIT(WD_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_o(gnt_o), .done_o(done_o), .err_o(err_o),
  .locked_o(locked_o), .timeout_o(timeout_o), .bus_en_o(bus_en_o)
);

// File: tb/tb_lock_arbiter.sv
module tb_lock_arbiter;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] req_i = '0, lock_i = '0, we_i = '0, bad_op_i = '0;
  logic [1:0] abort_i = '0, abort_irq_i = '0;
  logic [2*AW-1:0] addr_i = '0;
  logic [2*DW-1:0] wdata_i = '0;
  logic [1:0] gnt_o, done_o, err_o;
  logic [DW-1:0] rdata_o, bus_wdata_o, bus_rdata_i;
  logic locked_o, timeout_o, bus_en_o, bus_we_o;
  logic [AW-1:0] bus_addr_o;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  lock_arbiter #(.AW(AW), .DW(DW), .WD_LIMIT(WD)) dut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (bus_en_o && bus_we_o) begin
      mem[bus_addr_o] <= bus_wdata_o;
    end
  end
  assign bus_rdata_i = mem[bus_addr_o];

  // {m, lock, we, bad, addr[8], wdata[16], exp_err, lock_in_resp, lock_after, pad}
  localparam logic [31:0] VEC [13] = '{
    {1'b0,1'b0,1'b1,1'b0,8'h10,16'h1111,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,8'h10,16'h0000,1'b0,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0,8'h10,16'h0000,1'b0,1'b1,1'b1,1'b0},
    {1'b0,1'b1,1'b1,1'b0,8'h10,16'h2222,1'b0,1'b1,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b0,8'h10,16'h0000,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b0,1'b0,8'h20,16'h0000,1'b0,1'b1,1'b1,1'b0},
    {1'b1,1'b1,1'b1,1'b0,8'h21,16'h5555,1'b1,1'b1,1'b0,1'b0},
    {1'b0,1'b0,1'b1,1'b0,8'h20,16'h3333,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b0,1'b0,1'b1,8'h20,16'h0000,1'b1,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b1,1'b0,8'h20,16'h4444,1'b1,1'b0,1'b0,1'b0},
    {1'b1,1'b1,1'b0,1'b1,8'h30,16'h0000,1'b1,1'b0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b0,8'h20,16'h0000,1'b0,1'b1,1'b1,1'b0},
    {1'b0,1'b0,1'b0,1'b0,8'h20,16'h0000,1'b1,1'b1,1'b0,1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      2, 5, 11: return "R4";
      3:        return "R5";
      6, 12:    return "R6";
      8, 10:    return "R7";
      9:        return "R10";
      default:  return "R2";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit m, input bit r, input bit lk, input bit w, input bit b,
                       input logic [7:0] a, input logic [15:0] d);
    if (m) begin
      req_i[1] = r; lock_i[1] = lk; we_i[1] = w; bad_op_i[1] = b;
      addr_i[15:8] = a; wdata_i[31:16] = d;
    end else begin
      req_i[0] = r; lock_i[0] = lk; we_i[0] = w; bad_op_i[0] = b;
      addr_i[7:0] = a; wdata_i[15:0] = d;
    end
  endtask

  task automatic op(input bit m, input bit lk, input bit w, input bit b,
                    input logic [7:0] a, input logic [15:0] d,
                    input bit e_err, input bit e_ld, input bit e_la, input string tag);
    int n;
    @(negedge clk);
    drive(m, 1'b1, lk, w, b, a, d);
    n = 0;
    do begin @(negedge clk); n++; end while (!gnt_o[m] && n < 20);
    chk(gnt_o[m], {tag, " grant"}, gnt_o, m ? 2 : 1);
    chk(err_o[m] == e_err, {tag, " err"}, err_o[m], e_err);
    chk(done_o[m] == !e_err, {tag, " done"}, done_o[m], !e_err);
    chk(bus_en_o == !e_err, "R11 bus_en", bus_en_o, !e_err);
    if (!e_err) begin
      chk(bus_addr_o == a && bus_we_o == w, "R11 bus addr/we", {bus_we_o, bus_addr_o}, {w, a});
      if (w) begin
        chk(bus_wdata_o == d, "R11 bus wdata", bus_wdata_o, d);
        shadow[a] = d;
      end else begin
        chk(rdata_o == shadow[a], {tag, " rdata"}, rdata_o, shadow[a]);
      end
    end
    chk(locked_o == e_ld, {tag, " locked in response"}, locked_o, e_ld);
    drive(m, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000);
    @(negedge clk);
    chk(locked_o == e_la, {tag, " locked after"}, locked_o, e_la);
    chk(gnt_o == 2'b00, "R2 free cycle", gnt_o, 0);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    report();
    $finish;
  end

  initial begin
    int k;
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(gnt_o == 0 && done_o == 0 && err_o == 0, "R1 grant/resp", {gnt_o, done_o, err_o}, 0);
    chk(!locked_o && !timeout_o && !bus_en_o, "R1 lock/timeout/bus",
        {locked_o, timeout_o, bus_en_o}, 0);

    // R3 round robin, master 0 favoured after reset
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 16'h0);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h02, 16'h0);
    @(negedge clk);
    chk(gnt_o == 2'b01, "R3 first tie", gnt_o, 1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
    @(negedge clk);
    @(negedge clk);
    chk(gnt_o == 2'b10, "R3 waiting master", gnt_o, 2);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 16'h0);
    @(negedge clk);
    @(negedge clk);
    chk(gnt_o == 2'b01, "R3 tie after m1", gnt_o, 1);
    @(negedge clk);
    @(negedge clk);
    chk(gnt_o == 2'b10, "R3 tie after m0", gnt_o, 2);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
    @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      logic [31:0] v;
      v = VEC[i];
      op(v[31], v[30], v[29], v[28], v[27:20], v[19:4], v[3], v[2], v[1], tag_of(i));
    end

    // R4 other master held off while locked, owner's write wins the pending tie
    op(1'b0, 1'b1, 1'b0, 1'b0, 8'h40, 16'h0, 1'b0, 1'b1, 1'b1, "R4");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h40, 16'h0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(!gnt_o[1] && locked_o, "R4 blocked", {gnt_o, locked_o}, 3'b001);
    end
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h40, 16'h7777);
    @(negedge clk);
    chk(gnt_o == 2'b01 && done_o == 2'b01, "R5 owner first", {gnt_o, done_o}, 4'b0101);
    shadow[8'h40] = 16'h7777;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
    k = 0;
    do begin @(negedge clk); k++; end while (!gnt_o[1] && k < 10);
    chk(gnt_o[1] && rdata_o == 16'h7777, "R4 waiter gets new data", rdata_o, 16'h7777);
    chk(!locked_o, "R5 released", locked_o, 0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0);
    @(negedge clk);

    // R8 abort causes
    op(1'b0, 1'b1, 1'b0, 1'b0, 8'h50, 16'h0, 1'b0, 1'b1, 1'b1, "R8");
    abort_i = 2'b01; abort_irq_i = 2'b01;
    @(negedge clk);
    abort_i = 2'b00; abort_irq_i = 2'b00;
    chk(locked_o, "R8 interrupt abort ignored", locked_o, 1);
    abort_i = 2'b10;
    @(negedge clk);
    abort_i = 2'b00;
    chk(locked_o, "R8 non-owner abort ignored", locked_o, 1);
    abort_i = 2'b01;
    @(negedge clk);
    abort_i = 2'b00;
    chk(!locked_o && gnt_o == 0, "R8 exception releases", {locked_o, gnt_o}, 0);
    chk(!timeout_o, "R8 no timeout", timeout_o, 0);
    op(1'b1, 1'b0, 1'b1, 1'b0, 8'h50, 16'h8888, 1'b0, 1'b0, 1'b0, "R8");

    // R9 watchdog window
    op(1'b0, 1'b1, 1'b0, 1'b0, 8'h60, 16'h0, 1'b0, 1'b1, 1'b1, "R9");
    k = 2;
    while (locked_o && k < 40) begin @(negedge clk); if (locked_o) k++; end
    chk(k == WD, "R9 locked cycles", k, WD);
    chk(timeout_o, "R9 timeout set", timeout_o, 1);
    op(1'b0, 1'b1, 1'b1, 1'b0, 8'h60, 16'h9999, 1'b1, 1'b0, 1'b0, "R10");
    chk(timeout_o, "R9 sticky", timeout_o, 1);

    do_reset();
    chk(!timeout_o && !locked_o, "R1 reset clears timeout", {timeout_o, locked_o}, 0);

    report();
    $finish;
  end
endmodule